// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a software watchdog. Its timeout is held as four BCD digits in two byte-wide registers, so it spans 00.01 to 99.99 seconds. A one-cycle strobe from a 100 Hz time base drives the count down. When the count expires, the block pulses an alarm output and sets a watchdog flag. The block then reloads itself from the programmed value and keeps counting, so a host that stays silent sees the alarm repeat at the programmed interval.

The host keeps the alarm away by touching either timeout register at least once per interval. A read counts as a kick in the same way as a write. Readback always returns the programmed digits and never the live count. A programmed value of zero switches the watchdog off. The flag is also visible at bit 1 of a command address. That address can only be read, and reading it is not a kick.

Top module: `bcd_watchdog`

## Requirements
- R1: Address 0xC holds tenths in bits [7:4] and hundredths in bits [3:0]. Address 0xD holds tens of seconds in bits [7:4] and units in bits [3:0]. Each byte is written on its own, and the two may be written in either order.
- R2: A read or a write of 0xC or 0xD reloads the countdown from the stored value, including a byte written in that same cycle. From the next cycle on, the watchdog flag is 0.
- R3: After a reload with a timeout of N hundredths, the N-th tick produces an alarm. `wd_alarm_o` is high for exactly one cycle, the cycle after the clock edge that sampled that tick, and `wd_flag_o` becomes 1 in the same cycle.
- R4: With no access after an expiry, the count reloads and a further alarm pulse follows every N ticks. The flag stays 1 throughout.
- R5: A read of 0xC or 0xD returns the programmed byte on `bus_rdata_o` one cycle after the request and never the live count. `bus_rdata_o` holds its value between reads.
- R6: While the stored timeout is 00.00, ticks produce no alarm and do not set the flag.
- R7: The count decrements as four BCD digits with borrow through all digits. A timeout of 01.00 expires on the 100th tick, and 99.99 expires on the 9999th tick.
- R8: A read of address 0xB returns the flag at bit 1 with all other bits 0. Reading 0xB does not reload the count, and a write to 0xB has no effect.
- R9: When an access to 0xC or 0xD falls in the same cycle as a tick, the access takes effect and the tick is discarded.
- R10: After reset the stored timeout, the count, the flag, the alarm and `bus_rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 100 Hz |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |
| wd_flag_o | output | 1 | Watchdog flag, a level |
| wd_alarm_o | output | 1 | One-cycle pulse on each expiry |

## Verification
Read data, the flag and the alarm all come from registers. Each is therefore due in the first cycle after the edge that sampled the request or tick. The bench drives stimulus on falling edges and samples on the following falling edge. At the moment it drives a tick, the driver computes from its model of the requirements whether that tick must expire the count. If so, it queues the cycle number in which the alarm is due. A monitor compares every alarm pulse against the head of that queue and reports any late, early, extra or missing pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   localparam int unsigned BCD_DIGIT_W = 4;
   localparam logic [3:0]  BCD_MAX     = 4'd9;

   function automatic acc_kind_e classify(input logic valid, input logic write);
      if (!valid)     return ACC_NONE;
      else if (write) return ACC_WRITE;
      else            return ACC_READ;
   endfunction
endpackage

// File: rtl/wdt_bcd_digit.sv
module wdt_bcd_digit
   import wdt_pkg::*;
(
   input  logic [BCD_DIGIT_W-1:0] digit_i,
   input  logic                   borrow_i,
   output logic [BCD_DIGIT_W-1:0] digit_o,
   output logic                   borrow_o
);
   logic is_zero;
   assign is_zero = (digit_i == '0);

   always_comb begin
      if (!borrow_i)    digit_o = digit_i;
      else if (is_zero) digit_o = BCD_MAX;
      else              digit_o = digit_i - 1'b1;
   end

   assign borrow_o = borrow_i & is_zero;
endmodule

// File: rtl/wdt_bcd_dec.sv
module wdt_bcd_dec
   import wdt_pkg::*;
#(
   parameter int unsigned DIGITS = 4,
   localparam int unsigned VAL_W = DIGITS * BCD_DIGIT_W
)(
   input  logic [VAL_W-1:0] val_i,
   output logic [VAL_W-1:0] dec_o,
   output logic             is_one_o,
   output logic             is_zero_o
);
   logic [DIGITS:0] borrow;
   assign borrow[0] = 1'b1;

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      wdt_bcd_digit i_digit (
         .digit_i  (val_i[g*BCD_DIGIT_W +: BCD_DIGIT_W]),
         .borrow_i (borrow[g]),
         .digit_o  (dec_o[g*BCD_DIGIT_W +: BCD_DIGIT_W]),
         .borrow_o (borrow[g+1])
      );
   end

   assign is_one_o  = (val_i == VAL_W'(1));
   assign is_zero_o = (val_i == '0);
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
   import wdt_pkg::*;
#(
   parameter int unsigned      ADDR_W   = 4,
   parameter int unsigned      DATA_W   = 8,
   parameter logic [ADDR_W-1:0] LO_ADDR  = 4'hC,
   parameter logic [ADDR_W-1:0] HI_ADDR  = 4'hD,
   parameter logic [ADDR_W-1:0] CMD_ADDR = 4'hB,
   parameter int unsigned      FLAG_BIT = 1,
   localparam int unsigned     VAL_W    = 2 * DATA_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic              write_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              kick_o,
   output logic [VAL_W-1:0]  cfg_o,
   output logic [VAL_W-1:0]  reload_o
);
   acc_kind_e         kind;
   logic              hit_lo, hit_hi;
   logic [DATA_W-1:0] lo_q, hi_q, lo_d, hi_d;

   assign kind   = classify(valid_i, write_i);
   assign hit_lo = (kind != ACC_NONE) && (addr_i == LO_ADDR);
   assign hit_hi = (kind != ACC_NONE) && (addr_i == HI_ADDR);
   assign kick_o = hit_lo | hit_hi;

   assign lo_d = (hit_lo && kind == ACC_WRITE) ? wdata_i : lo_q;
   assign hi_d = (hit_hi && kind == ACC_WRITE) ? wdata_i : hi_q;

   assign reload_o = {hi_d, lo_d};
   assign cfg_o    = {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (kind == ACC_READ) begin
         if (addr_i == LO_ADDR)       rdata_o <= lo_q;
         else if (addr_i == HI_ADDR)  rdata_o <= hi_q;
         else if (addr_i == CMD_ADDR) rdata_o <= DATA_W'(flag_i) << FLAG_BIT;
         else                         rdata_o <= '0;
      end
   end

   // R1: a byte changes only when it is itself written
   p_lo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_i && write_i && addr_i == LO_ADDR) |=> $stable(lo_q));
   p_hi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_i && write_i && addr_i == HI_ADDR) |=> $stable(hi_q));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
   import wdt_pkg::*;
#(
   parameter int unsigned DIGITS = 4,
   localparam int unsigned VAL_W = DIGITS * BCD_DIGIT_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             kick_i,
   input  logic [VAL_W-1:0] cfg_i,
   input  logic [VAL_W-1:0] reload_i,
   output logic             expire_o
);
   logic [VAL_W-1:0] cnt_q, cnt_dec;
   logic             cnt_one, cnt_zero, step;

   wdt_bcd_dec #(.DIGITS(DIGITS)) i_dec (
      .val_i     (cnt_q),
      .dec_o     (cnt_dec),
      .is_one_o  (cnt_one),
      .is_zero_o (cnt_zero)
   );

   // R9: an access in the same cycle wins and the tick is dropped
   assign step     = tick_i && !kick_i && !cnt_zero;
   assign expire_o = step && cnt_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (kick_i)   cnt_q <= reload_i;
      else if (expire_o) cnt_q <= cfg_i;
      else if (step)     cnt_q <= cnt_dec;
   end

   // R2: an access loads the count from the new stored value
   p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> cnt_q == cfg_i);
   // R1: the live count never exceeds the stored timeout (BCD order equals binary order)
   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= cfg_i);
   // R6: a zero timeout keeps the counter idle
   p_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i == '0) |-> (cnt_q == '0));
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
   import wdt_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 4,
   parameter int unsigned       DATA_W   = 8,
   parameter logic [ADDR_W-1:0] LO_ADDR  = 4'hC,
   parameter logic [ADDR_W-1:0] HI_ADDR  = 4'hD,
   parameter logic [ADDR_W-1:0] CMD_ADDR = 4'hB,
   parameter int unsigned       FLAG_BIT = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              wd_flag_o,
   output logic              wd_alarm_o
);
   localparam int unsigned DIGITS = (2 * DATA_W) / BCD_DIGIT_W;
   localparam int unsigned VAL_W  = DIGITS * BCD_DIGIT_W;

   if (DATA_W % BCD_DIGIT_W != 0) begin : g_bad_width
      $error("DATA_W must hold whole BCD digits");
   end
   if (FLAG_BIT >= DATA_W) begin : g_bad_flag
      $error("FLAG_BIT outside the data word");
   end
   if (LO_ADDR == HI_ADDR || LO_ADDR == CMD_ADDR || HI_ADDR == CMD_ADDR) begin : g_bad_map
      $error("register addresses must differ");
   end

   logic             kick, expire;
   logic [VAL_W-1:0] cfg, reload;

   wdt_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_ADDR(LO_ADDR),
      .HI_ADDR(HI_ADDR), .CMD_ADDR(CMD_ADDR), .FLAG_BIT(FLAG_BIT)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (bus_valid_i),
      .write_i  (bus_write_i),
      .addr_i   (bus_addr_i),
      .wdata_i  (bus_wdata_i),
      .flag_i   (wd_flag_o),
      .rdata_o  (bus_rdata_o),
      .kick_o   (kick),
      .cfg_o    (cfg),
      .reload_o (reload)
   );

   wdt_countdown #(.DIGITS(DIGITS)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .kick_i   (kick),
      .cfg_i    (cfg),
      .reload_i (reload),
      .expire_o (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_flag_o  <= 1'b0;
         wd_alarm_o <= 1'b0;
      end else begin
         wd_alarm_o <= expire;
         if (kick)        wd_flag_o <= 1'b0;
         else if (expire) wd_flag_o <= 1'b1;
      end
   end

   // R2: an access clears the flag on the next cycle
   p_kick_clears_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid_i && (bus_addr_i == LO_ADDR || bus_addr_i == HI_ADDR)) |=> !wd_flag_o);
   // R3: every alarm pulse is accompanied by the flag
   p_alarm_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wd_alarm_o |-> wd_flag_o);
   // R6: no alarm while the timeout is zero
   p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg == '0) |-> !wd_alarm_o);
endmodule

// File: tb/test_bcd_watchdog.sv
module test_bcd_watchdog;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       valid = 1'b0;
   logic       write = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       flag, alarm;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   int exp_q[$];

   // model of the requirements
   logic [7:0] m_lo = 8'h00, m_hi = 8'h00;
   int m_rem = 0;
   bit m_flag = 0;

   bcd_watchdog i_bcd_watchdog (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .wd_flag_o(flag), .wd_alarm_o(alarm)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int total();
      return m_hi[7:4]*1000 + m_hi[3:0]*100 + m_lo[7:4]*10 + m_lo[3:0];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic void model_kick();
      m_rem  = total();
      m_flag = 0;
   endfunction

   task automatic bus_op(input bit wr, input logic [3:0] a, input logic [7:0] d,
                         input bit with_tick);
      @(negedge clk);
      valid = 1'b1; write = wr; addr = a; wdata = d; tick = with_tick;
      if (wr && a == 4'hC) m_lo = d;
      if (wr && a == 4'hD) m_hi = d;
      if (a == 4'hC || a == 4'hD) model_kick();
      @(negedge clk);
      valid = 1'b0; write = 1'b0; tick = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
      bus_op(0, a, 8'h00, 0);
      chk(req, rdata, exp);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
         if (total() != 0) begin
            m_rem--;
            if (m_rem == 0) begin
               exp_q.push_back(cyc + 1);
               m_rem  = total();
               m_flag = 1;
            end
         end
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   // monitor: scoreboard for alarm pulses (R3, R4, R6, R7)
   always @(negedge clk) begin
      if (rst_n) begin
         if (alarm) begin
            if (exp_q.size() == 0) begin
               chk("R3 unexpected alarm", 1, 0);
            end else begin
               chk("R3 alarm cycle", cyc, exp_q.pop_front());
            end
         end else if (exp_q.size() != 0 && exp_q[0] < cyc) begin
            chk("R3 missing alarm", cyc, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 rdata", rdata, 0);
      chk("R10 flag", flag, 0);
      chk("R10 alarm", alarm, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk(4'hC, 8'h00, "R10 lo reset");
      rd_chk(4'hD, 8'h00, "R10 hi reset");

      // R1 R3 R4: lo first then hi, 3 ticks, repeating alarm
      bus_op(1, 4'hC, 8'h03, 0);
      bus_op(1, 4'hD, 8'h00, 0);
      ticks(2);
      chk("R3 flag before expiry", flag, 0);
      ticks(1);
      chk("R3 flag after expiry", flag, 1);
      ticks(4);
      chk("R4 flag stays set", flag, 1);

      // R2 R5: reads kick, clear flag, return programmed value
      rd_chk(4'hD, 8'h00, "R5 hi readback");
      chk("R2 flag cleared by read", flag, 0);
      ticks(1);
      rd_chk(4'hC, 8'h03, "R5 lo readback not count");
      ticks(2);
      chk("R2 reload delayed expiry", flag, 0);
      ticks(1);
      chk("R2 expiry after reload", flag, m_flag);

      // R7 R1: hi first, 01.00 = 100 ticks with borrow
      bus_op(1, 4'hD, 8'h01, 0);
      bus_op(1, 4'hC, 8'h00, 0);
      ticks(99);
      chk("R7 no alarm before 100", flag, 0);
      ticks(1);
      chk("R7 alarm at 100", flag, 1);

      // R7: maximum 99.99
      bus_op(1, 4'hD, 8'h99, 0);
      bus_op(1, 4'hC, 8'h99, 0);
      ticks(9998);
      chk("R7 no alarm before 9999", flag, 0);
      ticks(1);
      chk("R7 alarm at 9999", flag, 1);

      // R8: flag at bit 1, read does not kick, write ignored
      bus_op(1, 4'hC, 8'h03, 0);
      bus_op(1, 4'hD, 8'h00, 0);
      ticks(2);
      rd_chk(4'hB, 8'h00, "R8 flag clear read");
      ticks(1);
      chk("R8 read of cmd did not reload", flag, 1);
      rd_chk(4'hB, 8'h02, "R8 flag bit 1");
      bus_op(1, 4'hB, 8'hFF, 0);
      rd_chk(4'hB, 8'h02, "R8 write ignored");

      // R9: access and tick in the same cycle
      bus_op(1, 4'hC, 8'h02, 0);
      ticks(1);
      bus_op(1, 4'hC, 8'h02, 1);
      ticks(1);
      chk("R9 tick dropped", flag, 0);
      ticks(1);
      chk("R9 expiry after full count", flag, 1);

      // R6: zero timeout disables
      bus_op(1, 4'hC, 8'h00, 0);
      ticks(20);
      chk("R6 no flag when disabled", flag, 0);
      rd_chk(4'hC, 8'h00, "R6 lo readback zero");

      repeat (4) @(negedge clk);
      chk("R3 all expected alarms seen", exp_q.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule